// File: doc/BRIEF.md
# SPI Transmit/Receive Byte Queues with Watermark Interrupt

This block sits between a processor register bus and the serial frame shifter of an SPI host controller. It holds two byte queues. Software fills the transmit queue by writing one register and empties the receive queue by reading another. The shifter drains the transmit queue and fills the receive queue through simple pop and push strobes. Each data register reports the state of its queue in bit 31, so a driver can poll without reading a separate status register.

Each queue has a programmable threshold. The transmit condition is true while the transmit queue holds fewer bytes than its threshold. The receive condition is true while the receive queue holds more bytes than its threshold. Both conditions are levels that follow the queue fill counts directly; they are never latched. Each condition has an enable bit, and the single interrupt line is the OR of the enabled conditions. A typical driver queues n bytes and sets the receive threshold to n-1. It then waits for the interrupt and reads the n bytes back.

Register offsets (byte addresses): 0x00 transmit data, 0x04 receive data, 0x08 transmit threshold, 0x0C receive threshold, 0x10 interrupt enable, 0x14 interrupt pending.

Top module: `spiq_dataq`

## Requirements
- R1: After reset both queues are empty, the transmit threshold is 1, the receive threshold is 0, both enables are 0 and `irq` is 0.
- R2: A write to the transmit data register (0x00) appends `reg_wdata[7:0]` to the transmit queue. The shifter sees the oldest byte on `tx_byte`, with `tx_avail` high while the queue is not empty. Each `tx_pop` advances it by one byte.
- R3: Reading 0x00 returns the transmit-full flag in bit 31 and 0 in every other bit. A write while the queue holds DEPTH (default 8) bytes is dropped.
- R4: Reading 0x04 with data present returns the oldest received byte in bits 7:0 with bit 31 clear, and removes that byte. Reading 0x04 while the queue is empty returns 0x8000_0000 and removes nothing.
- R5: An `rx_push` while the receive queue is full is dropped, and `rx_room` is low exactly while the queue is full.
- R6: Pending bit 0 (register 0x14) is 1 while the transmit queue holds strictly fewer bytes than the transmit threshold.
- R7: Pending bit 1 is 1 while the receive queue holds strictly more bytes than the receive threshold.
- R8: The pending register is read-only, and writes to 0x14 change nothing.
- R9: The enable register (0x10) uses bit 0 for the transmit condition and bit 1 for the receive condition. `irq` is the OR of pending bits ANDed with their enables.
- R10: The thresholds at 0x08 and 0x0C hold the low CNT_W bits of the written word (4 bits at the default depth) and read back zero-extended.
- R11: A `tx_pop` while the transmit queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x04) |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| tx_pop | input | 1 | Shifter has taken the head transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | Receive queue not full |
| irq | output | 1 | Watermark interrupt |

## Verification
On every cycle the assertions check four things. A push into a full queue leaves its fill count unchanged, and an empty-queue read or pop leaves it unchanged. An accepted write raises the count by one. The interrupt stays low while both enables are clear. Other behaviour only the directed scenarios can show: byte ordering through each queue, the exact values in the status bits, the threshold comparisons at their boundaries, that the pending register is read-only, and that the threshold field is truncated.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int ADDR_BITS = 5;
  localparam logic [ADDR_BITS-1:0] OFS_TXQ  = 5'h00;
  localparam logic [ADDR_BITS-1:0] OFS_RXQ  = 5'h04;
  localparam logic [ADDR_BITS-1:0] OFS_TXTH = 5'h08;
  localparam logic [ADDR_BITS-1:0] OFS_RXTH = 5'h0C;
  localparam logic [ADDR_BITS-1:0] OFS_IEN  = 5'h10;
  localparam logic [ADDR_BITS-1:0] OFS_IPND = 5'h14;

  localparam int WM_TX = 0;
  localparam int WM_RX = 1;

  // transmit watermark: fewer bytes queued than the threshold
  function automatic logic tx_below(input logic [15:0] lvl, input logic [15:0] th);
    return lvl < th;
  endfunction

  // receive watermark: more bytes queued than the threshold
  function automatic logic rx_above(input logic [15:0] lvl, input logic [15:0] th);
    return lvl > th;
  endfunction
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spiq_wmark.sv
module spiq_wmark #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] tx_lvl,
  input  logic [CW-1:0] rx_lvl,
  input  logic [CW-1:0] tx_th,
  input  logic [CW-1:0] rx_th,
  input  logic [1:0]    ien,
  output logic [1:0]    pend,
  output logic          irq
);
  import spiq_pkg::*;

  always_comb begin
    pend        = '0;
    pend[WM_TX] = tx_below(16'(tx_lvl), 16'(tx_th));
    pend[WM_RX] = rx_above(16'(rx_lvl), 16'(rx_th));
  end

  assign irq = |(pend & ien);
endmodule

// File: rtl/spiq_dataq.sv
module spiq_dataq #(
  parameter int DEPTH = 8,
  parameter int AW    = spiq_pkg::ADDR_BITS,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_pop,
  output logic [7:0]    tx_byte,
  output logic          tx_avail,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  output logic          rx_room,
  output logic          irq
);
  import spiq_pkg::*;

  // named events, also observed by the checker
  logic          tx_wr_evt, rx_rd_evt;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_lvl, rx_lvl;
  logic [7:0]    rx_head;
  logic [CW-1:0] tx_th, rx_th;
  logic [1:0]    ien, pend;

  assign tx_wr_evt = reg_wr && (reg_addr == AW'(OFS_TXQ));
  assign rx_rd_evt = reg_rd && (reg_addr == AW'(OFS_RXQ));

  spiq_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr_evt), .din(reg_wdata[7:0]),
    .pop(tx_pop), .dout(tx_byte),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  spiq_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_byte),
    .pop(rx_rd_evt), .dout(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign tx_avail = !tx_empty;
  assign rx_room  = !rx_full;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_th <= CW'(1);
      rx_th <= '0;
      ien   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(OFS_TXTH)) tx_th <= reg_wdata[CW-1:0];
      if (reg_addr == AW'(OFS_RXTH)) rx_th <= reg_wdata[CW-1:0];
      if (reg_addr == AW'(OFS_IEN))  ien   <= reg_wdata[1:0];
    end
  end

  spiq_wmark #(.CW(CW)) u_wm (
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .tx_th(tx_th), .rx_th(rx_th),
    .ien(ien), .pend(pend), .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_TXQ):  reg_rdata[31] = tx_full;
      AW'(OFS_RXQ):  begin
        reg_rdata[31]  = rx_empty;
        reg_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
      end
      AW'(OFS_TXTH): reg_rdata[CW-1:0] = tx_th;
      AW'(OFS_RXTH): reg_rdata[CW-1:0] = rx_th;
      AW'(OFS_IEN):  reg_rdata[1:0] = ien;
      AW'(OFS_IPND): reg_rdata[1:0] = pend;
      default:       reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spiq_dataq_chk.sv
module spiq_dataq_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_wr_evt,
  input logic          tx_pop,
  input logic          tx_pop_ok,
  input logic          tx_full,
  input logic          tx_empty,
  input logic [CW-1:0] tx_lvl,
  input logic          rx_push,
  input logic          rx_rd_evt,
  input logic          rx_full,
  input logic          rx_empty,
  input logic [CW-1:0] rx_lvl,
  input logic [1:0]    ien,
  input logic          irq
);
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_evt && tx_full && !tx_pop_ok |=> $stable(tx_lvl)); // R3

  AST_TX_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_evt && !tx_full && !tx_pop |=> tx_lvl == $past(tx_lvl) + CW'(1)); // R2

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_evt && rx_empty && !rx_push |=> $stable(rx_lvl)); // R4

  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rx_rd_evt |=> $stable(rx_lvl)); // R5

  AST_TX_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_empty && !tx_wr_evt |=> tx_lvl == '0); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 2'b00 |-> !irq); // R9
endmodule

bind spiq_dataq spiq_dataq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_wr_evt(tx_wr_evt), .tx_pop(tx_pop), .tx_pop_ok(tx_pop_ok),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_lvl(tx_lvl),
  .rx_push(rx_push), .rx_rd_evt(rx_rd_evt),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_lvl(rx_lvl),
  .ien(ien), .irq(irq)
);

// File: tb/sim_spiq_dataq.sv
`timescale 1ns/1ps
module sim_spiq_dataq;
  localparam logic [4:0] A_TXQ = 5'h00, A_RXQ = 5'h04, A_TXTH = 5'h08,
                         A_RXTH = 5'h0C, A_IEN = 5'h10, A_IPND = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_avail;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_room;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  spiq_dataq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_room(rx_room), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FIAL_GUARD");
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk); reg_rd = 1'b0;
    #1;
  endtask

  task automatic shpop(output logic [7:0] b);
    @(negedge clk); tx_pop = 1'b1; #1 b = tx_byte;
    @(posedge clk); @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic shpush(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_byte = b;
    @(posedge clk); @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic t_reset;
    rd(A_TXQ, got);  chk("R1 txq after reset", got, 32'h0);
    rd(A_RXQ, got);  chk("R1 rxq after reset", got, 32'h8000_0000);
    rd(A_TXTH, got); chk("R1 tx threshold", got, 32'd1);
    rd(A_RXTH, got); chk("R1 rx threshold", got, 32'd0);
    rd(A_IEN, got);  chk("R1 enables", got, 32'd0);
    rd(A_IPND, got); chk("R1 R6 pending empty", got, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx_avail", {31'd0, tx_avail}, 32'd0);
  endtask

  task automatic t_tx_fill;
    logic [7:0] b;
    for (int i = 0; i < 8; i++) wr(A_TXQ, 32'h1234_5600 | (32'hA0 + 32'(i)));
    rd(A_TXQ, got); chk("R3 full flag", got, 32'h8000_0000);
    wr(A_TXQ, 32'h55);
    rd(A_IPND, got); chk("R6 full not pending", got & 32'h1, 32'd0);
    for (int i = 0; i < 8; i++) begin
      shpop(b); chk("R2 tx order", {24'd0, b}, 32'hA0 + 32'(i));
    end
    chk("R3 ninth write dropped", {31'd0, tx_avail}, 32'd0);
    shpop(b);
    wr(A_TXQ, 32'h77);
    chk("R11 pop on empty ignored", {23'd0, tx_avail, tx_byte}, 32'h177);
    shpop(b);
    rd(A_TXQ, got); chk("R3 not full", got, 32'h0);
  endtask

  task automatic t_rx_path;
    wr(A_RXTH, 32'd2);
    shpush(8'h11); shpush(8'h22);
    rd(A_IPND, got); chk("R7 two at threshold 2", got & 32'h2, 32'd0);
    shpush(8'h33);
    rd(A_IPND, got); chk("R7 three above 2", got & 32'h2, 32'h2);
    rd(A_RXQ, got); chk("R4 rx byte 1", got, 32'h11);
    rd(A_RXQ, got); chk("R4 rx byte 2", got, 32'h22);
    rd(A_RXQ, got); chk("R4 rx byte 3", got, 32'h33);
    rd(A_RXQ, got); chk("R4 empty read", got, 32'h8000_0000);
    shpush(8'h44);
    rd(A_RXQ, got); chk("R4 nothing popped by empty read", got, 32'h44);
    wr(A_RXTH, 32'd0);
  endtask

  task automatic t_rx_overflow;
    for (int i = 0; i < 9; i++) shpush(8'hC0 + 8'(i));
    chk("R5 rx_room low when full", {31'd0, rx_room}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(A_RXQ, got); chk("R5 rx order", got, 32'hC0 + 32'(i));
    end
    rd(A_RXQ, got); chk("R5 ninth push dropped", got, 32'h8000_0000);
    chk("R5 rx_room back", {31'd0, rx_room}, 32'd1);
  endtask

  task automatic t_tx_mark;
    logic [7:0] b;
    wr(A_TXTH, 32'd3);
    wr(A_TXQ, 32'h1); wr(A_TXQ, 32'h2);
    rd(A_IPND, got); chk("R6 two below 3", got & 32'h1, 32'h1);
    wr(A_TXQ, 32'h3);
    rd(A_IPND, got); chk("R6 three not below 3", got & 32'h1, 32'h0);
    for (int i = 0; i < 3; i++) shpop(b);
    wr(A_TXTH, 32'd1);
  endtask

  task automatic t_irq;
    wr(A_IEN, 32'h1);
    chk("R9 tx enabled irq", {31'd0, irq}, 32'd1);
    wr(A_IEN, 32'h2);
    chk("R9 rx enabled no data", {31'd0, irq}, 32'd0);
    shpush(8'h5A);
    chk("R9 rx irq", {31'd0, irq}, 32'd1);
    wr(A_IPND, 32'h0);
    rd(A_IPND, got); chk("R8 pending unchanged by write", got, 32'h3);
    rd(A_RXQ, got);
    chk("R9 irq drops after read", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'h0);
    chk("R9 masked", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_thresh;
    wr(A_TXTH, 32'hFFFF_FFF5);
    rd(A_TXTH, got); chk("R10 tx threshold field", got, 32'h5);
    wr(A_RXTH, 32'h0000_00A7);
    rd(A_RXTH, got); chk("R10 rx threshold field", got, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_tx_fill;
    t_rx_path;
    t_rx_overflow;
    t_tx_mark;
    t_irq;
    t_thresh;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule